// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits between an 8-bit processor with a 16-bit address bus and the ROM and RAM chips of a plug-in cartridge. The cartridge ROM is read-only, so processor writes anywhere in the lower 32 KB are taken as control writes. They set four pieces of state: a RAM gate, a five-bit low bank field, a two-bit shared field and a banking mode. On every access the block forms the physical ROM and RAM addresses from that state. It drives the chip selects and returns the read byte to the processor.

The lower 16 KB of the processor's view always shows ROM bank 0. The next 16 KB shows a switchable bank. The 8 KB window at 0xA000-0xBFFF shows one 8 KB bank of cartridge RAM, and only while the RAM gate is open. Two states decide what the shared two-bit field means. In `MODE_ROM` it supplies ROM bank bits 6:5 and the RAM bank is 0. In `MODE_RAM` it selects the RAM bank and the ROM bank uses only the low five bits. The transition `TO_RAM` is taken on a mode write with data bit 0 set while in `MODE_ROM`. The transition `TO_ROM` is taken on a mode write with data bit 0 clear while in `MODE_RAM`. Any other mode write stays in the current state.

The installed ROM bank count and RAM bank count are parameters. Bank numbers are trimmed to the installed size when they are stored.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A write (cpu_wr high) to 0x0000-0x1FFF opens the RAM gate when cpu_wdata[3:0] is 4'hA, whatever the upper nibble. Any other low nibble closes it.
- R2: While the gate is closed, an access to 0xA000-0xBFFF keeps ram_cs and ram_we low and returns 8'h00 on cpu_rdata. A write there leaves RAM untouched.
- R3: A write to 0x2000-0x3FFF loads cpu_wdata[4:0] into the low bank field, and data bits 7:5 are ignored. A value of zero is stored as one.
- R4: In `MODE_ROM`, a write to 0x4000-0x5FFF puts cpu_wdata[1:0] into switchable ROM bank bits 6:5, and the RAM bank stays 0.
- R5: In `MODE_RAM`, a write to 0x4000-0x5FFF selects RAM bank cpu_wdata[1:0], and the ROM bank is the low field alone. This happens only when RAM_BANKS is nonzero.
- R6: A write to 0x6000-0x7FFF sets the mode from cpu_wdata[0] (0 = `MODE_ROM`, 1 = `MODE_RAM`). A write that changes the mode clears the shared field, so ROM bits 6:5 and the RAM bank both become 0. A write that repeats the current mode changes nothing.
- R7: The stored ROM bank is ANDed with (the smallest power of two at or above ROM_BANKS) minus 1. The RAM bank is masked the same way against RAM_BANKS. With the default 64 ROM banks, bit 6 is always 0.
- R8: rom_cs is high for 0x0000-0x7FFF. For 0x0000-0x3FFF, rom_addr is {7'd0, cpu_addr[13:0]}. For 0x4000-0x7FFF, rom_addr is {bank[6:0], cpu_addr[13:0]}.
- R9: ram_addr is {ram_bank[1:0], cpu_addr[12:0]}. ram_cs is high in 0xA000-0xBFFF while the gate is open, and ram_we equals ram_cs AND cpu_wr. rom_cs and ram_cs are never high together.
- R10: After reset, the switchable ROM bank is 1, the mode is `MODE_ROM`, the gate is closed and the RAM bank is 0.
- R11: cpu_rdata returns rom_rdata in 0x0000-0x7FFF and ram_rdata when ram_cs is high. Every other address returns 8'hFF.
- R12: The control state changes only on a rising clock edge that sees cpu_wr high with cpu_addr in 0x0000-0x7FFF. Writes to 0x8000 and above leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_wr | input | 1 | Processor write strobe |
| rom_rdata | input | 8 | Byte returned by cartridge ROM |
| ram_rdata | input | 8 | Byte returned by cartridge RAM |
| rom_addr | output | 21 | Physical ROM byte address |
| rom_cs | output | 1 | ROM chip select |
| ram_addr | output | 15 | Physical RAM byte address |
| ram_cs | output | 1 | RAM chip select |
| ram_we | output | 1 | RAM write enable |
| cpu_rdata | output | 8 | Byte returned to the processor |

## Verification
A corrupted low field, shared field or mode shows up in the bank bits of rom_addr or ram_addr. It appears on the first access to 0x4000-0x7FFF or 0xA000-0xBFFF after the faulty write. Every register feeds the outputs combinationally, so the error is visible in the cycle after the clock edge that caught the write. A wrong gate state shows up as ram_cs or cpu_rdata in the RAM window during that same cycle. This is why each write in the stimulus is followed at once by a probe of both windows.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

    localparam int LO_W      = 5;
    localparam int HI_W      = 2;
    localparam int BANK_W    = LO_W + HI_W;
    localparam int ROM_OFS_W = 14;
    localparam int RAM_OFS_W = 13;

    // banking mode: meaning of the shared two-bit field
    typedef enum logic {
        MODE_ROM = 1'b0,
        MODE_RAM = 1'b1
    } bank_mode_e;

    // decoded control write target
    typedef enum logic [2:0] {
        CTL_NONE  = 3'd0,
        CTL_GATE  = 3'd1,
        CTL_LO    = 3'd2,
        CTL_SHARE = 3'd3,
        CTL_MODE  = 3'd4
    } ctl_sel_e;

    // access window seen by the processor
    typedef enum logic [1:0] {
        WIN_ROM_FIXED = 2'd0,
        WIN_ROM_SWAP  = 2'd1,
        WIN_XRAM      = 2'd2,
        WIN_NONE      = 2'd3
    } win_e;

    // next power of two at or above count, minus one
    function automatic int size_mask(input int count);
        int n;
        n = 1;
        while (n < count) n = n << 1;
        return n - 1;
    endfunction

endpackage

// File: rtl/cart_addr_decode.sv
module cart_addr_decode
    import cart_bank_pkg::*;
(
    input  logic [15:0] cpu_addr,
    input  logic        cpu_wr,
    output ctl_sel_e    ctl_sel,
    output win_e        win
);

    always_comb begin
        ctl_sel = CTL_NONE;
        if (cpu_wr && !cpu_addr[15]) begin
            unique case (cpu_addr[14:13])
                2'b00:   ctl_sel = CTL_GATE;
                2'b01:   ctl_sel = CTL_LO;
                2'b10:   ctl_sel = CTL_SHARE;
                default: ctl_sel = CTL_MODE;
            endcase
        end
    end

    always_comb begin
        if (!cpu_addr[15])
            win = cpu_addr[14] ? WIN_ROM_SWAP : WIN_ROM_FIXED;
        else if (cpu_addr[15:13] == 3'b101)
            win = WIN_XRAM;
        else
            win = WIN_NONE;
    end

endmodule

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
    import cart_bank_pkg::*;
#(
    parameter logic [LO_W-1:0] LO_MASK     = 5'h1F,
    parameter logic [HI_W-1:0] HI_ROM_MASK = 2'b11,
    parameter logic [HI_W-1:0] HI_RAM_MASK = 2'b11,
    parameter bit              HAS_RAM     = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_sel_e          ctl_sel,
    input  logic [7:0]        wdata,
    output logic              gate_open,
    output logic [LO_W-1:0]   bank_lo,
    output logic [HI_W-1:0]   bank_share,
    output bank_mode_e        mode,
    output logic [BANK_W-1:0] rom_bank,
    output logic [HI_W-1:0]   ram_bank
);

    localparam logic [LO_W-1:0] LO_RESET = LO_W'(1) & LO_MASK;

    bank_mode_e      mode_q, mode_d;
    logic            mode_flip;
    logic            gate_q, gate_d;
    logic [LO_W-1:0] lo_q, lo_d, lo_wr;
    logic [HI_W-1:0] sh_q, sh_d;

    // next-state of the mode machine
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_ROM: if (ctl_sel == CTL_MODE &&  wdata[0]) mode_d = MODE_RAM;
            MODE_RAM: if (ctl_sel == CTL_MODE && !wdata[0]) mode_d = MODE_ROM;
            default:  mode_d = MODE_ROM;
        endcase
    end

    assign mode_flip = (mode_d != mode_q);
    assign lo_wr     = (wdata[LO_W-1:0] == '0) ? LO_W'(1) : wdata[LO_W-1:0];

    always_comb begin
        gate_d = gate_q;
        lo_d   = lo_q;
        sh_d   = sh_q;
        unique case (ctl_sel)
            CTL_GATE:  gate_d = (wdata[3:0] == 4'hA);
            CTL_LO:    lo_d   = lo_wr & LO_MASK;
            CTL_SHARE: begin
                if (mode_q == MODE_ROM)
                    sh_d = wdata[HI_W-1:0] & HI_ROM_MASK;
                else if (HAS_RAM)
                    sh_d = wdata[HI_W-1:0] & HI_RAM_MASK;
            end
            CTL_MODE: begin
                if (mode_flip) begin
                    lo_d = ((lo_q == '0) ? LO_W'(1) : lo_q) & LO_MASK;
                    sh_d = '0;
                end
            end
            default: ;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_ROM;
            gate_q <= 1'b0;
            lo_q   <= LO_RESET;
            sh_q   <= '0;
        end else begin
            mode_q <= mode_d;
            gate_q <= gate_d;
            lo_q   <= lo_d;
            sh_q   <= sh_d;
        end
    end

    // outputs: what the shared field means in each state
    always_comb begin
        unique case (mode_q)
            MODE_ROM: begin
                rom_bank = {sh_q, lo_q};
                ram_bank = '0;
            end
            MODE_RAM: begin
                rom_bank = {{HI_W{1'b0}}, lo_q};
                ram_bank = sh_q;
            end
            default: begin
                rom_bank = {{HI_W{1'b0}}, lo_q};
                ram_bank = '0;
            end
        endcase
    end

    assign gate_open  = gate_q;
    assign bank_lo    = lo_q;
    assign bank_share = sh_q;
    assign mode       = mode_q;

endmodule

// File: rtl/cart_phys_map.sv
module cart_phys_map
    import cart_bank_pkg::*;
#(
    parameter bit HAS_RAM = 1'b1
) (
    input  win_e              win,
    input  logic [15:0]       cpu_addr,
    input  logic              cpu_wr,
    input  logic              gate_open,
    input  logic [BANK_W-1:0] rom_bank,
    input  logic [HI_W-1:0]   ram_bank,
    input  logic [7:0]        rom_rdata,
    input  logic [7:0]        ram_rdata,
    output logic [BANK_W+ROM_OFS_W-1:0] rom_addr,
    output logic              rom_cs,
    output logic [HI_W+RAM_OFS_W-1:0]   ram_addr,
    output logic              ram_cs,
    output logic              ram_we,
    output logic [7:0]        cpu_rdata
);

    logic [BANK_W-1:0] bank_sel;
    logic              xram_hit;

    always_comb begin
        unique case (win)
            WIN_ROM_SWAP: bank_sel = rom_bank;
            default:      bank_sel = '0;
        endcase
    end

    assign rom_addr = {bank_sel, cpu_addr[ROM_OFS_W-1:0]};
    assign rom_cs   = (win == WIN_ROM_FIXED) || (win == WIN_ROM_SWAP);
    assign ram_addr = {ram_bank, cpu_addr[RAM_OFS_W-1:0]};

    generate
        if (HAS_RAM) begin : g_ram
            assign xram_hit = (win == WIN_XRAM) && gate_open;
        end else begin : g_noram
            assign xram_hit = 1'b0;
        end
    endgenerate

    assign ram_cs = xram_hit;
    assign ram_we = xram_hit && cpu_wr;

    always_comb begin
        unique case (win)
            WIN_ROM_FIXED, WIN_ROM_SWAP: cpu_rdata = rom_rdata;
            WIN_XRAM:                    cpu_rdata = xram_hit ? ram_rdata : 8'h00;
            default:                     cpu_rdata = 8'hFF;
        endcase
    end

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import cart_bank_pkg::*;
#(
    parameter int ROM_BANKS = 64,
    parameter int RAM_BANKS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_wdata,
    input  logic        cpu_wr,
    input  logic [7:0]  rom_rdata,
    input  logic [7:0]  ram_rdata,
    output logic [20:0] rom_addr,
    output logic        rom_cs,
    output logic [14:0] ram_addr,
    output logic        ram_cs,
    output logic        ram_we,
    output logic [7:0]  cpu_rdata
);

    localparam int                ROM_MASK_I  = size_mask(ROM_BANKS);
    localparam int                RAM_MASK_I  = size_mask(RAM_BANKS);
    localparam logic [BANK_W-1:0] ROM_MASK    = ROM_MASK_I[BANK_W-1:0];
    localparam logic [LO_W-1:0]   LO_MASK     = ROM_MASK[LO_W-1:0];
    localparam logic [HI_W-1:0]   HI_ROM_MASK = ROM_MASK[BANK_W-1:LO_W];
    localparam logic [HI_W-1:0]   HI_RAM_MASK = RAM_MASK_I[HI_W-1:0];
    localparam bit                HAS_RAM     = (RAM_BANKS > 0);

    ctl_sel_e          ctl_sel;
    win_e              win;
    logic              gate_open;
    logic [LO_W-1:0]   bank_lo;
    logic [HI_W-1:0]   bank_share;
    bank_mode_e        mode;
    logic [BANK_W-1:0] rom_bank;
    logic [HI_W-1:0]   ram_bank;

    cart_addr_decode u_dec (
        .cpu_addr (cpu_addr),
        .cpu_wr   (cpu_wr),
        .ctl_sel  (ctl_sel),
        .win      (win)
    );

    cart_bank_regs #(
        .LO_MASK     (LO_MASK),
        .HI_ROM_MASK (HI_ROM_MASK),
        .HI_RAM_MASK (HI_RAM_MASK),
        .HAS_RAM     (HAS_RAM)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_sel    (ctl_sel),
        .wdata      (cpu_wdata),
        .gate_open  (gate_open),
        .bank_lo    (bank_lo),
        .bank_share (bank_share),
        .mode       (mode),
        .rom_bank   (rom_bank),
        .ram_bank   (ram_bank)
    );

    cart_phys_map #(
        .HAS_RAM (HAS_RAM)
    ) u_map (
        .win       (win),
        .cpu_addr  (cpu_addr),
        .cpu_wr    (cpu_wr),
        .gate_open (gate_open),
        .rom_bank  (rom_bank),
        .ram_bank  (ram_bank),
        .rom_rdata (rom_rdata),
        .ram_rdata (ram_rdata),
        .rom_addr  (rom_addr),
        .rom_cs    (rom_cs),
        .ram_addr  (ram_addr),
        .ram_cs    (ram_cs),
        .ram_we    (ram_we),
        .cpu_rdata (cpu_rdata)
    );

endmodule

// File: rtl/cart_bank_ctrl_chk.sv
module cart_bank_ctrl_chk #(
    parameter logic [4:0] LO_MASK = 5'h1F
) (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_wdata,
    input logic        cpu_wr,
    input logic [20:0] rom_addr,
    input logic        rom_cs,
    input logic        ram_cs,
    input logic        ram_we,
    input logic [7:0]  cpu_rdata,
    input logic [4:0]  bank_lo,
    input logic [1:0]  bank_share,
    input logic        mode_bit
);

    a_r1_gate_close: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:13] == 3'b000 && cpu_wdata[3:0] != 4'hA)
        |=> (!ram_cs && !ram_we));

    a_r2_closed_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:13] == 3'b101 && !ram_cs) |-> (cpu_rdata == 8'h00 && !ram_we));

    a_r3_zero_forced_one: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:13] == 3'b001 && cpu_wdata[4:0] == 5'd0)
        |=> (bank_lo == (5'd1 & LO_MASK)));

    a_r6_flip_clears_share: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:13] == 3'b011 && cpu_wdata[0] != mode_bit)
        |=> (bank_share == 2'b00));

    a_r8_fixed_bank_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b00) |-> (rom_addr[20:14] == 7'd0 && rom_cs));

    a_r9_cs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rom_cs, ram_cs}));

    a_r9_we_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_cs && cpu_wr));

    a_r12_high_write_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15]) |=> ($stable(bank_lo) && $stable(bank_share) && $stable(mode_bit)));

endmodule

bind cart_bank_ctrl cart_bank_ctrl_chk #(.LO_MASK(LO_MASK)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_wr     (cpu_wr),
    .rom_addr   (rom_addr),
    .rom_cs     (rom_cs),
    .ram_cs     (ram_cs),
    .ram_we     (ram_we),
    .cpu_rdata  (cpu_rdata),
    .bank_lo    (bank_lo),
    .bank_share (bank_share),
    .mode_bit   (mode)
);

// File: tb/cart_bank_ctrl_test.sv
module cart_bank_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h8000;
    logic [7:0]  cpu_wdata = 8'h00;
    logic        cpu_wr = 1'b0;
    logic [7:0]  rom_rdata = 8'h3C;
    logic [7:0]  ram_rdata = 8'hC3;
    logic [20:0] rom_addr;
    logic        rom_cs;
    logic [14:0] ram_addr;
    logic        ram_cs;
    logic        ram_we;
    logic [7:0]  cpu_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cart_bank_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_wr    (cpu_wr),
        .rom_rdata (rom_rdata),
        .ram_rdata (ram_rdata),
        .rom_addr  (rom_addr),
        .rom_cs    (rom_cs),
        .ram_addr  (ram_addr),
        .ram_cs    (ram_cs),
        .ram_we    (ram_we),
        .cpu_rdata (cpu_rdata)
    );

    // {write addr, write data, expected ROM bank, expected RAM bank, expected ram_cs}
    localparam int NVEC = 16;
    localparam logic [33:0] VEC [NVEC] = '{
        {16'h0000, 8'h0A, 7'h01, 2'd0, 1'b1},  // R1 open
        {16'h2000, 8'h00, 7'h01, 2'd0, 1'b1},  // R3 zero -> one
        {16'h2100, 8'h05, 7'h05, 2'd0, 1'b1},  // R3
        {16'h4000, 8'h01, 7'h25, 2'd0, 1'b1},  // R4
        {16'h2000, 8'h20, 7'h21, 2'd0, 1'b1},  // R3 upper bits ignored
        {16'h5FFF, 8'h03, 7'h21, 2'd0, 1'b1},  // R7 bit 6 masked
        {16'h6000, 8'h01, 7'h01, 2'd0, 1'b1},  // R6 flip clears share
        {16'h4000, 8'h02, 7'h01, 2'd2, 1'b1},  // R5 RAM bank
        {16'h2000, 8'h07, 7'h07, 2'd2, 1'b1},  // R5 low field alone
        {16'h7000, 8'h03, 7'h07, 2'd2, 1'b1},  // R6 same mode, no change
        {16'h1000, 8'h1B, 7'h07, 2'd2, 1'b0},  // R1 close
        {16'h1FFF, 8'hFA, 7'h07, 2'd2, 1'b1},  // R1 upper nibble ignored
        {16'h6000, 8'h00, 7'h07, 2'd0, 1'b1},  // R6 back to ROM mode
        {16'h9000, 8'h55, 7'h07, 2'd0, 1'b1},  // R12 high write ignored
        {16'h3FFF, 8'h1F, 7'h1F, 2'd0, 1'b1},  // R3
        {16'h4000, 8'h02, 7'h1F, 2'd0, 1'b1}   // R7 bank bit 6 masked off
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr  = a;
        cpu_wdata = d;
        cpu_wr    = 1'b1;
        @(negedge clk);
        cpu_wr    = 1'b0;
        cpu_addr  = 16'h8000;
    endtask

    task automatic probe(input logic [15:0] a);
        cpu_wr   = 1'b0;
        cpu_addr = a;
        #1;
    endtask

    task automatic check_reset_state();
        probe(16'h4123);
        check("R10 rom bank 1", 32'(rom_addr), {11'd0, 7'h01, 14'h0123});
        probe(16'hA456);
        check("R10 ram bank 0", 32'(ram_addr), {17'd0, 2'd0, 13'h0456});
        check("R10 gate closed cs", 32'(ram_cs), 32'd0);
        check("R10 gate closed rdata", 32'(cpu_rdata), 32'h00);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all-reqs actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state();

        for (int i = 0; i < NVEC; i++) begin
            do_write(VEC[i][33:18], VEC[i][17:10]);
            probe(16'h4123);
            check($sformatf("R3-R7 vec%0d rom bank", i), 32'(rom_addr),
                  {11'd0, VEC[i][9:3], 14'h0123});
            probe(16'hA456);
            check($sformatf("R9 vec%0d ram addr", i), 32'(ram_addr),
                  {17'd0, VEC[i][2:1], 13'h0456});
            check($sformatf("R1 vec%0d ram_cs", i), 32'(ram_cs), 32'(VEC[i][0]));
        end

        // R8 fixed bank and rom_cs
        probe(16'h3ABC);
        check("R8 fixed bank addr", 32'(rom_addr), 32'h0003ABC);
        check("R8 rom_cs", 32'(rom_cs), 32'd1);
        check("R11 rom rdata", 32'(cpu_rdata), 32'h3C);
        probe(16'h7FFF);
        check("R8 swap top", 32'(rom_addr), {11'd0, 7'h1F, 14'h3FFF});

        // R9 / R11 open gate
        probe(16'hBCDE);
        check("R9 ram addr", 32'(ram_addr), 32'h1CDE);
        check("R11 ram rdata", 32'(cpu_rdata), 32'hC3);
        check("R9 rom_cs low in ram window", 32'(rom_cs), 32'd0);
        cpu_wr = 1'b1;
        #1;
        check("R9 ram_we", 32'(ram_we), 32'd1);
        cpu_wr = 1'b0;
        probe(16'hC000);
        check("R11 outside reads FF", 32'(cpu_rdata), 32'hFF);
        check("R9 no cs outside", 32'({rom_cs, ram_cs}), 32'd0);

        // R2 closed gate blocks writes
        do_write(16'h0000, 8'h00);
        probe(16'hA000);
        cpu_wr = 1'b1;
        #1;
        check("R2 ram_we blocked", 32'(ram_we), 32'd0);
        check("R2 ram_cs blocked", 32'(ram_cs), 32'd0);
        check("R2 rdata zero", 32'(cpu_rdata), 32'h00);
        @(negedge clk);
        cpu_wr = 1'b0;
        probe(16'h4000);
        check("R12 ram-window write keeps bank", 32'(rom_addr), {11'd0, 7'h1F, 14'h0000});

        // R10 mid-run reset
        do_write(16'h6000, 8'h01);
        do_write(16'h4000, 8'h03);
        do_write(16'h0000, 8'h0A);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state();
        do_write(16'h4000, 8'h02);
        probe(16'h4000);
        check("R10 mode is ROM after reset", 32'(rom_addr), {11'd0, 7'h41 & 7'h3F, 14'h0});

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule